// File: doc/BRIEF.md
# Paged I2C Register Interface for an LED Matrix Controller

This block is an I2C target that lets a host program the register file of an LED matrix controller. It receives already-sampled SCL and SDA levels. It pulls the shared data line low through an open-drain enable. The register file has two parts. A small global space holds a page selector, a write-lock key, an interrupt mask, an interrupt status view and an identity byte. Three pages sit behind the selector: a per-LED brightness array, a per-LED current-scaling array, and a function page with the operating configuration, the global current and the pull-resistor selection.

All writable contents are exported as plain vectors to the scan and fault logic. The page selector is protected by a one-shot key, so a stray write cannot redirect later traffic to another page. A magic byte written to the function page returns the whole file to its defaults. Releasing the shutdown input restarts the serial engine but keeps every register.

Top module: `led_page_i2c_target`

## Requirements
- R1: The target answers the 7-bit address made of binary 01100, then `strap_i[1:0]`, with the R/W bit as the eighth bit (0 = write, 1 = read). With strap 00 the write byte is 0x60, and with strap 10 it is 0x64. A matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R2: A non-matching address byte is not acknowledged. SDA stays released for the rest of the transfer, and further bytes are neither acknowledged nor acted on until the next START.
- R3: A write transfer consists of the address byte, a register-address byte, then data bytes, each sent MSB first. Each of these bytes is acknowledged.
- R4: The register pointer advances by one (wrapping at 8 bits) after every data byte, whether written or read, so a burst covers consecutive addresses.
- R5: The page selector at 0xFD accepts 0x00 (brightness), 0x02 (scaling) and 0x04 (function). Any other value leaves the page unchanged. The page is 0x00 after reset. Reads of 0xFD return 0x00.
- R6: A write to 0xFD takes effect only while the key register 0xFE holds 0xC5. Any write to 0xFD made while unlocked clears 0xFE to 0x00, whether or not the value was legal. 0xFE is readable and writable.
- R7: A read is a write transfer that sets the pointer, then a repeated START and the read address byte. The target sends bytes MSB first. It continues after a master ACK and releases SDA after a master NACK.
- R8: Address 0xFC is read-only and returns the target's own 8-bit write address {01100, strap, 0}.
- R9: On page 0x00 (or 0x02), addresses 0 to LED_COUNT-1 hold one brightness (or scaling) byte per LED. Byte i is exported at bits [8i+7:8i] of `bright_o` (or `scale_o`).
- R10: The function page holds configuration at 0x00, global current at 0x01, and pull selection at 0x02 (default 0x55). Writing 0xAE to 0x3F restores every register to its default: page 0, key 0, mask 0, pull 0x55, all else 0. Any other value written to 0x3F does nothing.
- R11: Unimplemented addresses, including brightness or scaling indices at or above LED_COUNT and writes to 0xF1 or 0xFC, read as 0x00 where readable, and writes to them change nothing.
- R12: A rising edge on `shdn_n_i` returns the serial engine to idle, abandoning any transfer, while register contents stay unchanged.
- R13: 0xF0 is a readable and writable interrupt mask exported on `irq_mask_o`. 0xF1 reads {6'b0, `irq_status_i`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled serial clock level |
| sda_i | input | 1 | Sampled serial data level |
| shdn_n_i | input | 1 | Shutdown, active low; rising edge restarts the serial engine |
| strap_i | input | 2 | Address strap bits |
| irq_status_i | input | 2 | Short (bit 1) and open (bit 0) flags from fault logic |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| bright_o | output | LED_COUNT*8 | Brightness bytes, LED i at [8i+7:8i] |
| scale_o | output | LED_COUNT*8 | Current-scaling bytes, LED i at [8i+7:8i] |
| cfg_o | output | 8 | Configuration register |
| gcc_o | output | 8 | Global current register |
| pull_o | output | 8 | Pull-resistor selection register |
| irq_mask_o | output | 8 | Interrupt mask register |

## Verification
The bench builds the block with LED_COUNT = 12. At that size, a two-byte burst starting at the last LED runs straight into the first unimplemented index, so the array edge and the discard rule for out-of-range writes are both reached in short transfers. It drives the strap at both 00 and 10 to move the device address and the identity byte, and it sets the status input to a non-zero pattern. It also lands a shutdown release in the middle of a write, so that abandonment and retention are both observed at the ports.

// File: rtl/led_regs_pkg.sv
package led_regs_pkg;

    localparam int BYTE_W = 8;

    localparam logic [4:0] DEV_PREFIX   = 5'b01100;

    localparam logic [7:0] ADDR_MASK    = 8'hF0;
    localparam logic [7:0] ADDR_STAT    = 8'hF1;
    localparam logic [7:0] ADDR_ID      = 8'hFC;
    localparam logic [7:0] ADDR_PAGE    = 8'hFD;
    localparam logic [7:0] ADDR_KEY     = 8'hFE;
    localparam logic [7:0] GLOBAL_BASE  = 8'hF0;

    localparam logic [7:0] KEY_UNLOCK   = 8'hC5;
    localparam logic [7:0] PAGE_BRIGHT  = 8'h00;
    localparam logic [7:0] PAGE_SCALE   = 8'h02;
    localparam logic [7:0] PAGE_FUNC    = 8'h04;

    localparam logic [7:0] FN_CFG       = 8'h00;
    localparam logic [7:0] FN_GCC       = 8'h01;
    localparam logic [7:0] FN_PULL      = 8'h02;
    localparam logic [7:0] FN_RESET     = 8'h3F;
    localparam logic [7:0] RESET_MAGIC  = 8'hAE;
    localparam logic [7:0] PULL_DEFAULT = 8'h55;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_REG,
        ST_ACK_REG,
        ST_WDATA,
        ST_ACK_WR,
        ST_TX,
        ST_TX_ACK
    } eng_state_e;

endpackage

// File: rtl/led_i2c_engine.sv
module led_i2c_engine
    import led_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                shdn_n_i,
    input  logic [1:0]          strap_i,
    input  logic [BYTE_W-1:0]   rd_data_i,
    output logic                sda_oe_o,
    output logic [BYTE_W-1:0]   rd_addr_o,
    output logic                wr_stb_o,
    output logic [BYTE_W-1:0]   wr_addr_o,
    output logic [BYTE_W-1:0]   wr_data_o
);

    typedef struct packed {
        eng_state_e         state;
        logic [3:0]         bit_cnt;
        logic [BYTE_W-1:0]  shreg;
        logic [BYTE_W-1:0]  ptr;
        logic               rw;
        logic               mnack;
        logic               oe;
        logic               scl_prev;
        logic               sda_prev;
        logic               shdn_prev;
        logic               wr_stb;
        logic [BYTE_W-1:0]  wr_addr;
        logic [BYTE_W-1:0]  wr_data;
    } eng_t;

    localparam eng_t ENG_RST = '{state: ST_IDLE, bit_cnt: '0, shreg: '0, ptr: '0,
                                 rw: 1'b0, mnack: 1'b0, oe: 1'b0, scl_prev: 1'b1,
                                 sda_prev: 1'b1, shdn_prev: 1'b1, wr_stb: 1'b0,
                                 wr_addr: '0, wr_data: '0};

    eng_t eng_d, eng_q;

    logic [6:0] dev_addr;
    logic       scl_rise, scl_fall, bus_start, bus_stop, bus_rst;

    assign dev_addr  = {DEV_PREFIX, strap_i};
    assign scl_rise  = scl_i & ~eng_q.scl_prev;
    assign scl_fall  = ~scl_i & eng_q.scl_prev;
    assign bus_start = scl_i & eng_q.scl_prev & eng_q.sda_prev & ~sda_i;
    assign bus_stop  = scl_i & eng_q.scl_prev & ~eng_q.sda_prev & sda_i;
    assign bus_rst   = shdn_n_i & ~eng_q.shdn_prev;

    always_comb begin
        eng_d           = eng_q;
        eng_d.wr_stb    = 1'b0;
        eng_d.scl_prev  = scl_i;
        eng_d.sda_prev  = sda_i;
        eng_d.shdn_prev = shdn_n_i;
        if (bus_rst || bus_stop) begin
            eng_d.state = ST_IDLE;
            eng_d.oe    = 1'b0;
        end else if (bus_start) begin
            eng_d.state   = ST_ADDR;
            eng_d.bit_cnt = '0;
            eng_d.oe      = 1'b0;
        end else begin
            case (eng_q.state)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (scl_rise && eng_q.bit_cnt < 4'd8) begin
                        eng_d.shreg   = {eng_q.shreg[BYTE_W-2:0], sda_i};
                        eng_d.bit_cnt = eng_q.bit_cnt + 4'd1;
                    end else if (scl_fall && eng_q.bit_cnt == 4'd8) begin
                        eng_d.bit_cnt = '0;
                        eng_d.oe      = 1'b1;
                        if (eng_q.state == ST_ADDR) begin
                            eng_d.rw    = eng_q.shreg[0];
                            eng_d.state = ST_ACK_ADDR;
                            if (eng_q.shreg[BYTE_W-1:1] != dev_addr) begin
                                eng_d.oe    = 1'b0;
                                eng_d.state = ST_IDLE;
                            end
                        end else if (eng_q.state == ST_REG) begin
                            eng_d.ptr   = eng_q.shreg;
                            eng_d.state = ST_ACK_REG;
                        end else begin
                            eng_d.wr_stb  = 1'b1;
                            eng_d.wr_addr = eng_q.ptr;
                            eng_d.wr_data = eng_q.shreg;
                            eng_d.state   = ST_ACK_WR;
                        end
                    end
                end
                ST_ACK_ADDR: if (scl_fall) begin
                    if (eng_q.rw) begin
                        eng_d.shreg = rd_data_i;
                        eng_d.oe    = ~rd_data_i[BYTE_W-1];
                        eng_d.state = ST_TX;
                    end else begin
                        eng_d.oe    = 1'b0;
                        eng_d.state = ST_REG;
                    end
                end
                ST_ACK_REG: if (scl_fall) begin
                    eng_d.oe    = 1'b0;
                    eng_d.state = ST_WDATA;
                end
                ST_ACK_WR: if (scl_fall) begin
                    eng_d.oe    = 1'b0;
                    eng_d.ptr   = eng_q.ptr + 8'd1;
                    eng_d.state = ST_WDATA;
                end
                ST_TX: if (scl_fall) begin
                    if (eng_q.bit_cnt == 4'd7) begin
                        eng_d.bit_cnt = '0;
                        eng_d.oe      = 1'b0;
                        eng_d.ptr     = eng_q.ptr + 8'd1;
                        eng_d.state   = ST_TX_ACK;
                    end else begin
                        eng_d.shreg   = {eng_q.shreg[BYTE_W-2:0], 1'b0};
                        eng_d.oe      = ~eng_q.shreg[BYTE_W-2];
                        eng_d.bit_cnt = eng_q.bit_cnt + 4'd1;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        eng_d.mnack = sda_i;
                    end else if (scl_fall) begin
                        if (eng_q.mnack) begin
                            eng_d.state = ST_IDLE;
                        end else begin
                            eng_d.shreg = rd_data_i;
                            eng_d.oe    = ~rd_data_i[BYTE_W-1];
                            eng_d.state = ST_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= ENG_RST;
        else        eng_q <= eng_d;
    end

    assign sda_oe_o  = eng_q.oe;
    assign rd_addr_o = eng_q.ptr;
    assign wr_stb_o  = eng_q.wr_stb;
    assign wr_addr_o = eng_q.wr_addr;
    assign wr_data_o = eng_q.wr_data;

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.oe) |-> !eng_q.scl_prev); // R3

    AST_MISMATCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_ADDR && scl_fall && eng_q.bit_cnt == 4'd8 && !bus_rst &&
         eng_q.shreg[BYTE_W-1:1] != dev_addr) |=> (!eng_q.oe && eng_q.state == ST_IDLE)); // R2

    AST_SHDN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (eng_q.state == ST_IDLE && !eng_q.oe)); // R12

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_IDLE) |-> !eng_q.oe); // R2

endmodule

// File: rtl/led_reg_file.sv
module led_reg_file
    import led_regs_pkg::*;
#(
    parameter int LED_COUNT = 180
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb_i,
    input  logic [BYTE_W-1:0]           wr_addr_i,
    input  logic [BYTE_W-1:0]           wr_data_i,
    input  logic [BYTE_W-1:0]           rd_addr_i,
    output logic [BYTE_W-1:0]           rd_data_o,
    input  logic [1:0]                  strap_i,
    input  logic [1:0]                  irq_status_i,
    output logic [LED_COUNT*BYTE_W-1:0] bright_o,
    output logic [LED_COUNT*BYTE_W-1:0] scale_o,
    output logic [BYTE_W-1:0]           cfg_o,
    output logic [BYTE_W-1:0]           gcc_o,
    output logic [BYTE_W-1:0]           pull_o,
    output logic [BYTE_W-1:0]           irq_mask_o
);

    localparam int IDX_W = (LED_COUNT > 1) ? $clog2(LED_COUNT) : 1;

    typedef struct packed {
        logic [BYTE_W-1:0]                  page;
        logic [BYTE_W-1:0]                  key;
        logic [BYTE_W-1:0]                  mask;
        logic [BYTE_W-1:0]                  cfg;
        logic [BYTE_W-1:0]                  gcc;
        logic [BYTE_W-1:0]                  pull;
        logic [LED_COUNT-1:0][BYTE_W-1:0]   bright;
        logic [LED_COUNT-1:0][BYTE_W-1:0]   scale;
    } regs_t;

    localparam regs_t REGS_RST = '{page: PAGE_BRIGHT, key: '0, mask: '0, cfg: '0, gcc: '0,
                                   pull: PULL_DEFAULT, bright: '0, scale: '0};

    regs_t regs_d, regs_q;

    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             wr_in_range, rd_in_range, page_legal;

    assign wr_idx      = wr_addr_i[IDX_W-1:0];
    assign rd_idx      = rd_addr_i[IDX_W-1:0];
    assign wr_in_range = int'(wr_addr_i) < LED_COUNT;
    assign rd_in_range = int'(rd_addr_i) < LED_COUNT;
    assign page_legal  = (wr_data_i == PAGE_BRIGHT) || (wr_data_i == PAGE_SCALE) ||
                         (wr_data_i == PAGE_FUNC);

    always_comb begin
        regs_d = regs_q;
        if (wr_stb_i) begin
            if (wr_addr_i == ADDR_PAGE) begin
                if (regs_q.key == KEY_UNLOCK) begin
                    regs_d.key = '0;
                    if (page_legal) regs_d.page = wr_data_i;
                end
            end else if (wr_addr_i == ADDR_KEY) begin
                regs_d.key = wr_data_i;
            end else if (wr_addr_i == ADDR_MASK) begin
                regs_d.mask = wr_data_i;
            end else if (wr_addr_i < GLOBAL_BASE) begin
                if (regs_q.page == PAGE_BRIGHT && wr_in_range) begin
                    regs_d.bright[wr_idx] = wr_data_i;
                end else if (regs_q.page == PAGE_SCALE && wr_in_range) begin
                    regs_d.scale[wr_idx] = wr_data_i;
                end else if (regs_q.page == PAGE_FUNC) begin
                    case (wr_addr_i)
                        FN_CFG:   regs_d.cfg  = wr_data_i;
                        FN_GCC:   regs_d.gcc  = wr_data_i;
                        FN_PULL:  regs_d.pull = wr_data_i;
                        FN_RESET: if (wr_data_i == RESET_MAGIC) regs_d = REGS_RST;
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_ID) begin
            rd_data_o = {DEV_PREFIX, strap_i, 1'b0};
        end else if (rd_addr_i == ADDR_KEY) begin
            rd_data_o = regs_q.key;
        end else if (rd_addr_i == ADDR_MASK) begin
            rd_data_o = regs_q.mask;
        end else if (rd_addr_i == ADDR_STAT) begin
            rd_data_o = {6'b0, irq_status_i};
        end else if (rd_addr_i < GLOBAL_BASE) begin
            if (regs_q.page == PAGE_BRIGHT && rd_in_range) begin
                rd_data_o = regs_q.bright[rd_idx];
            end else if (regs_q.page == PAGE_SCALE && rd_in_range) begin
                rd_data_o = regs_q.scale[rd_idx];
            end else if (regs_q.page == PAGE_FUNC) begin
                case (rd_addr_i)
                    FN_CFG:  rd_data_o = regs_q.cfg;
                    FN_GCC:  rd_data_o = regs_q.gcc;
                    FN_PULL: rd_data_o = regs_q.pull;
                    default: rd_data_o = '0;
                endcase
            end
        end
    end

    assign bright_o   = regs_q.bright;
    assign scale_o    = regs_q.scale;
    assign cfg_o      = regs_q.cfg;
    assign gcc_o      = regs_q.gcc;
    assign pull_o     = regs_q.pull;
    assign irq_mask_o = regs_q.mask;

    AST_PAGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.page == PAGE_BRIGHT || regs_q.page == PAGE_SCALE ||
         regs_q.page == PAGE_FUNC)); // R5

    AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_addr_i == ADDR_PAGE && regs_q.key == KEY_UNLOCK)
        |=> (regs_q.key == 8'h00)); // R6

    AST_LOCKED_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_addr_i == ADDR_PAGE && regs_q.key != KEY_UNLOCK)
        |=> $stable(regs_q.page)); // R6

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_addr_i == FN_RESET && regs_q.page == PAGE_FUNC &&
         wr_data_i == RESET_MAGIC)
        |=> (regs_q.pull == PULL_DEFAULT && regs_q.page == PAGE_BRIGHT &&
             regs_q.key == 8'h00)); // R10

endmodule

// File: rtl/led_page_i2c_target.sv
module led_page_i2c_target
    import led_regs_pkg::*;
#(
    parameter int LED_COUNT = 180
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    input  logic                        shdn_n_i,
    input  logic [1:0]                  strap_i,
    input  logic [1:0]                  irq_status_i,
    output logic                        sda_oe_o,
    output logic [LED_COUNT*BYTE_W-1:0] bright_o,
    output logic [LED_COUNT*BYTE_W-1:0] scale_o,
    output logic [BYTE_W-1:0]           cfg_o,
    output logic [BYTE_W-1:0]           gcc_o,
    output logic [BYTE_W-1:0]           pull_o,
    output logic [BYTE_W-1:0]           irq_mask_o
);

    logic [BYTE_W-1:0] rd_addr, rd_data, wr_addr, wr_data;
    logic              wr_stb;

    led_i2c_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .shdn_n_i  (shdn_n_i),
        .strap_i   (strap_i),
        .rd_data_i (rd_data),
        .sda_oe_o  (sda_oe_o),
        .rd_addr_o (rd_addr),
        .wr_stb_o  (wr_stb),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    led_reg_file #(.LED_COUNT(LED_COUNT)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb_i     (wr_stb),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .strap_i      (strap_i),
        .irq_status_i (irq_status_i),
        .bright_o     (bright_o),
        .scale_o      (scale_o),
        .cfg_o        (cfg_o),
        .gcc_o        (gcc_o),
        .pull_o       (pull_o),
        .irq_mask_o   (irq_mask_o)
    );

endmodule

// File: tb/led_page_i2c_target_tb_top.sv
`timescale 1ns/1ps
module led_page_i2c_target_tb_top;

    localparam int N = 12;
    localparam int Q = 4;
    typedef logic [7:0] byte_q_t [$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_low = 1'b0;
    logic shdn_n = 1'b1;
    logic [1:0] strap = 2'b00;
    logic [1:0] irq = 2'b00;
    logic sda_oe;
    logic [N*8-1:0] bright, scale;
    logic [7:0] cfg, gcc, pull, mask;
    wire sda_line = !(sda_low || sda_oe);

    int checks = 0;
    int errors = 0;
    int cmp_prints = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    led_page_i2c_target #(.LED_COUNT(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .shdn_n_i(shdn_n),
        .strap_i(strap), .irq_status_i(irq), .sda_oe_o(sda_oe), .bright_o(bright),
        .scale_o(scale), .cfg_o(cfg), .gcc_o(gcc), .pull_o(pull), .irq_mask_o(mask));

    // behavioural reference model
    int         m_page, m_key;
    logic [7:0] m_bright [N];
    logic [7:0] m_scale  [N];
    logic [7:0] m_cfg, m_gcc, m_pull, m_mask;

    task automatic model_reset();
        m_page = 0; m_key = 0; m_cfg = 0; m_gcc = 0; m_pull = 8'h55; m_mask = 0;
        for (int i = 0; i < N; i++) begin m_bright[i] = 0; m_scale[i] = 0; end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] v);
        if (a == 8'hFD) begin
            if (m_key == 8'hC5) begin
                m_key = 0;
                if (v == 0 || v == 2 || v == 4) m_page = v;
            end
        end else if (a == 8'hFE) m_key = v;
        else if (a == 8'hF0) m_mask = v;
        else if (a < 8'hF0) begin
            if (m_page == 0 && a < N) m_bright[a] = v;
            else if (m_page == 2 && a < N) m_scale[a] = v;
            else if (m_page == 4) begin
                if (a == 0) m_cfg = v;
                else if (a == 1) m_gcc = v;
                else if (a == 2) m_pull = v;
                else if (a == 8'h3F && v == 8'hAE) model_reset();
            end
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'hFC) return {5'b01100, strap, 1'b0};
        if (a == 8'hFE) return m_key[7:0];
        if (a == 8'hF0) return m_mask;
        if (a == 8'hF1) return {6'b0, irq};
        if (a >= 8'hF0) return 8'h00;
        if (m_page == 0) return (a < N) ? m_bright[a] : 8'h00;
        if (m_page == 2) return (a < N) ? m_scale[a] : 8'h00;
        if (a == 0) return m_cfg;
        if (a == 1) return m_gcc;
        if (a == 2) return m_pull;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison of all exports against the model (R9, R10, R13)
    always @(negedge clk) begin
        if (rst_n && scl_drv && !done) begin
            logic [N*8-1:0] eb, es;
            for (int i = 0; i < N; i++) begin eb[i*8 +: 8] = m_bright[i]; es[i*8 +: 8] = m_scale[i]; end
            checks++;
            if ({bright, scale, cfg, gcc, pull, mask} !== {eb, es, m_cfg, m_gcc, m_pull, m_mask}) begin
                errors++;
                if (cmp_prints < 5) begin
                    cmp_prints++;
                    $display("FAIL R9/R10/R13 exports: actual %h %h %h %h %h %h expected %h %h %h %h %h %h",
                             bright, scale, cfg, gcc, pull, mask, eb, es, m_cfg, m_gcc, m_pull, m_mask);
                end
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_low = 1'b0; wt(Q); scl_drv = 1'b1; wt(Q); sda_low = 1'b1; wt(Q); scl_drv = 1'b0; wt(Q);
    endtask

    task automatic i2c_stop();
        sda_low = 1'b1; wt(Q); scl_drv = 1'b1; wt(Q); sda_low = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit commit, input logic [7:0] ca,
                             output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_low = !b[i]; wt(Q); scl_drv = 1'b1; wt(2*Q); scl_drv = 1'b0;
        end
        sda_low = 1'b0; wt(Q);
        if (commit) model_write(ca, b);
        scl_drv = 1'b1; wt(Q); ack = !sda_line; wt(Q); scl_drv = 1'b0;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wt(Q); scl_drv = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl_drv = 1'b0;
        end
        sda_low = !nack; wt(Q); scl_drv = 1'b1; wt(2*Q); scl_drv = 1'b0; sda_low = 1'b0;
    endtask

    function automatic logic [7:0] dev(input bit rd);
        return {5'b01100, strap, rd};
    endfunction

    task automatic wr_burst(input logic [7:0] ra, input byte_q_t data, output int nacks);
        bit a;
        nacks = 0;
        i2c_start();
        send_byte(dev(0), 0, 0, a); if (!a) nacks++;
        send_byte(ra, 0, 0, a); if (!a) nacks++;
        foreach (data[k]) begin
            send_byte(data[k], 1, ra + 8'(k), a); if (!a) nacks++;
        end
        i2c_stop();
    endtask

    task automatic wr1(input logic [7:0] ra, input logic [7:0] v);
        int n;
        byte_q_t q;
        q.push_back(v);
        wr_burst(ra, q, n);
        chk("R3 write acks", n, 0);
    endtask

    task automatic rd_check(input string req, input logic [7:0] ra, input int n);
        bit a;
        logic [7:0] b;
        i2c_start();
        send_byte(dev(0), 0, 0, a);
        send_byte(ra, 0, 0, a);
        i2c_start();
        send_byte(dev(1), 0, 0, a);
        chk("R7 read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            chk(req, b, model_read(ra + 8'(k)));
        end
        wt(2);
        chk("R7 released after NACK", sda_line, 1);
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        bit a;
        byte_q_t q;
        model_reset();
        wt(5); rst_n = 1'b1; wt(5);

        // reset state
        chk("R10 pull default", pull, 8'h55);
        chk("R9 bright reset", bright[7:0], 8'h00);
        chk("R2 sda released at reset", sda_oe, 0);

        // R1 R3 basic write at strap 00 (0x60)
        wr1(8'h00, 8'h11);
        chk("R9 bright[0]", bright[7:0], 8'h11);

        // R4 burst write and burst read
        q = '{8'hA1, 8'hA2, 8'hA3};
        wr_burst(8'h03, q, n);
        chk("R4 burst acks", n, 0);
        chk("R4 bright[5]", bright[5*8 +: 8], 8'hA3);
        rd_check("R4 burst read", 8'h03, 3);

        // R5 R6 locked page select
        wr1(8'hFD, 8'h02);
        wr1(8'h00, 8'h5A);
        chk("R6 locked page ignored", bright[7:0], 8'h5A);
        chk("R6 scale untouched", scale[7:0], 8'h00);

        // R6 unlock once
        wr1(8'hFE, 8'hC5);
        rd_check("R6 key readable", 8'hFE, 1);
        wr1(8'hFD, 8'h02);
        rd_check("R6 key cleared", 8'hFE, 1);
        wr1(8'h01, 8'h77);
        chk("R6 scale page active", scale[15:8], 8'h77);
        wr1(8'hFD, 8'h00);
        wr1(8'h02, 8'h66);
        chk("R6 unlock single use", scale[23:16], 8'h66);

        // R5 illegal page value
        wr1(8'hFE, 8'hC5);
        wr1(8'hFD, 8'h03);
        rd_check("R5 key cleared by illegal", 8'hFE, 1);
        wr1(8'h00, 8'h99);
        chk("R5 illegal page ignored", scale[7:0], 8'h99);

        // R9 R11 array edge
        q = '{8'h3C, 8'h4D};
        wr_burst(8'(N - 1), q, n);
        chk("R9 last entry", scale[(N-1)*8 +: 8], 8'h3C);
        rd_check("R11 past end reads 0", 8'(N), 1);

        // R10 function page
        wr1(8'hFE, 8'hC5);
        wr1(8'hFD, 8'h04);
        q = '{8'h81, 8'h42, 8'h17};
        wr_burst(8'h00, q, n);
        chk("R10 cfg", cfg, 8'h81);
        chk("R10 gcc", gcc, 8'h42);
        rd_check("R10 pull read", 8'h02, 1);
        wr1(8'h3F, 8'h12);
        chk("R10 wrong magic ignored", pull, 8'h17);

        // R13 mask and status
        wr1(8'hF0, 8'h13);
        chk("R13 mask export", mask, 8'h13);
        rd_check("R13 mask read", 8'hF0, 1);
        irq = 2'b10;
        wr1(8'hF1, 8'hFF);
        rd_check("R13 R11 status read", 8'hF1, 1);
        rd_check("R11 page reg reads 0", 8'hFD, 1);

        // R8 identity
        rd_check("R8 id strap 00", 8'hFC, 1);

        // R10 soft reset
        wr1(8'h3F, 8'hAE);
        chk("R10 reset pull", pull, 8'h55);
        chk("R10 reset mask", mask, 8'h00);
        chk("R10 reset bright", bright == '0, 1);
        wr1(8'h00, 8'h21);
        chk("R10 page back to 0", bright[7:0], 8'h21);

        // R2 mismatch
        i2c_start();
        send_byte(8'h62, 0, 0, a);
        chk("R2 mismatch nack", a, 0);
        send_byte(8'h00, 0, 0, a);
        chk("R2 later byte nack", a, 0);
        i2c_stop();

        // R1 R8 other strap
        strap = 2'b10;
        rd_check("R8 id strap 10", 8'hFC, 1);
        i2c_start();
        send_byte(8'h60, 0, 0, a);
        chk("R1 old address nack", a, 0);
        i2c_stop();
        strap = 2'b00;

        // R12 shutdown release mid transfer
        i2c_start();
        send_byte(dev(0), 0, 0, a);
        send_byte(8'h07, 0, 0, a);
        shdn_n = 1'b0; wt(3); shdn_n = 1'b1; wt(3);
        send_byte(8'h55, 0, 0, a);
        chk("R12 abandoned transfer", a, 0);
        i2c_stop();
        chk("R12 no write", bright[7*8 +: 8], 8'h00);
        chk("R12 retained", bright[7:0], 8'h21);
        wr1(8'h07, 8'h44);
        chk("R12 engine usable", bright[7*8 +: 8], 8'h44);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule